// File: doc/BRIEF.md
# Block-Ordered Memory Operation Queue

This block releases the loads and stores of one atomic instruction block to memory in the order set by their small identifiers. When the block is fetched, the queue is given a presence vector with one bit for each identifier the block uses. The operations then reach the queue in any order, carrying an identifier, a direction (load or store) and an address. Each one is offered on the issue port once the ordering rule allows it. Completions come back by identifier. When every identifier in the vector has completed, the queue pulses commit and becomes free for the next block.

In the strict mode, an operation waits until every lower identifier has completed. An identifier missing from the vector counts as complete. In the speculative mode, a load may go ahead of stores with lower identifiers that are still outstanding. The exception is a lower store that has already arrived with the same address, which the load must wait for. Stores always keep the strict rule. If a store arrives whose identifier is below that of a load to the same address that has already been issued or completed, the queue raises a squash pulse naming the lowest such load. All the loads hit by that store lose their issued and completed state and are offered again later.

The arrival port and the issue port are valid/ready. An arrival is taken on a cycle where both valid and ready are high. Ready is high only while a block is active and not yet committing. The issue port holds the lowest eligible operation on its outputs while ready stays low. If a lower identifier becomes eligible before the handshake, the offer switches to that lower operation. The fetch-vector, completion, mode, commit, squash and error pins are plain single-cycle controls.

Top module: `lsq_order_top`

## Requirements
- R1: After reset, iss_valid, commit, squash_valid and mask_err are 0 and op_ready is 0.
- R2: A mask_valid pulse while no block is active loads mask_bits (bit i set means identifier i belongs to the block), and op_ready is 1 from the next cycle.
- R3: A mask_valid pulse while a block is active raises mask_err for exactly the next cycle and leaves the active block's vector unchanged.
- R4: In strict mode (spec_en = 0), an arrived operation is offered only when every lower identifier set in the vector has completed; identifiers not in the vector count as complete.
- R5: The issue port offers the lowest eligible identifier with its direction (iss_store = 1 for a store) and address, holds it while iss_ready is 0, and takes at most one operation per cycle.
- R6: An arrival whose identifier is not in the vector is ignored and never offered for issue.
- R7: A completion for an identifier that has not been issued is ignored.
- R8: Commit is a one-cycle pulse in the cycle after the last vector identifier completes; op_ready is 0 during the pulse; an empty vector commits in the cycle after it is loaded.
- R9: In speculative mode (spec_en = 1), a load is offered ahead of incomplete lower stores that have not arrived or that have a different address, while a store still waits for all lower identifiers.
- R10: In speculative mode, a load is held while an arrived, incomplete store with a lower identifier has the same address.
- R11: A store arriving with a lower identifier and the same address as an issued or completed load raises squash_valid for one cycle, with squash_id set to the lowest such load, and those loads are offered for issue again.
- R12: When a completion and a squash hit the same load in the same cycle, the squash wins: the load is not complete and is offered again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| spec_en | input | 1 | 1 selects speculative load issue |
| mask_valid | input | 1 | Presents a new identifier vector |
| mask_bits | input | NUM_ID | Identifier presence vector |
| mask_err | output | 1 | Vector rejected because a block is active |
| op_valid | input | 1 | Arrival valid |
| op_ready | output | 1 | Arrival ready |
| op_id | input | ID_W | Arriving identifier |
| op_store | input | 1 | Arriving operation is a store |
| op_addr | input | ADDR_W | Arriving address |
| iss_valid | output | 1 | Issue offer valid |
| iss_ready | input | 1 | Memory accepts the offer |
| iss_id | output | ID_W | Offered identifier |
| iss_store | output | 1 | Offered operation is a store |
| iss_addr | output | ADDR_W | Offered address |
| cpl_valid | input | 1 | Completion valid |
| cpl_id | input | ID_W | Completed identifier |
| commit | output | 1 | Block commit pulse |
| squash_valid | output | 1 | Squash pulse |
| squash_id | output | ID_W | Lowest squashed load |

## Verification
Two events can land on the same load in one cycle: its completion, and the arrival of a lower store to the same address that squashes it. The bench provokes this by issuing two speculative loads and completing one of them. It then drives the conflicting store arrival together with the completion of the other load on a single clock edge. The result is judged at the ports: the squash pulse must name the lower load, commit must stay low, and that load must be offered for issue again once the store has completed.

// File: rtl/lsq_pkg.sv
package lsq_pkg;
  typedef enum logic {
    PH_IDLE = 1'b0,
    PH_RUN  = 1'b1
  } blk_phase_e;
endpackage

// File: rtl/lsq_pick.sv
module lsq_pick #(
  parameter int N = 32,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  req,
  output logic [N-1:0]  gnt,
  output logic [IW-1:0] idx,
  output logic          any
);
  assign any = |req;
  assign gnt = req & (~req + {{(N-1){1'b0}}, 1'b1});

  always_comb begin
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) idx = IW'(i);
    end
  end
endmodule

// File: rtl/lsq_hazard.sv
module lsq_hazard #(
  parameter int NUM_ID = 32,
  parameter int ADDR_W = 16,
  localparam int ID_W = $clog2(NUM_ID)
) (
  input  logic                           spec_en,
  input  logic [NUM_ID-1:0]              mask_q,
  input  logic [NUM_ID-1:0]              arr_q,
  input  logic [NUM_ID-1:0]              st_q,
  input  logic [NUM_ID-1:0]              iss_q,
  input  logic [NUM_ID-1:0]              done_q,
  input  logic [NUM_ID-1:0][ADDR_W-1:0]  addr_q,
  input  logic [NUM_ID-1:0]              hs_vec,
  input  logic                           new_st,
  input  logic [ID_W-1:0]                new_id,
  input  logic [ADDR_W-1:0]              new_addr,
  output logic [NUM_ID-1:0]              elig,
  output logic [NUM_ID-1:0]              conf
);
  logic [NUM_ID-1:0] finished;
  assign finished = done_q | ~mask_q;

  always_comb begin
    logic prefix_ok;
    logic same_blk;
    prefix_ok = 1'b1;
    for (int i = 0; i < NUM_ID; i++) begin
      same_blk = 1'b0;
      for (int j = 0; j < i; j++) begin
        if (mask_q[j] && arr_q[j] && st_q[j] && !done_q[j] && (addr_q[j] == addr_q[i]))
          same_blk = 1'b1;
      end
      if (spec_en && !st_q[i])
        elig[i] = mask_q[i] & arr_q[i] & ~iss_q[i] & ~done_q[i] & ~same_blk;
      else
        elig[i] = mask_q[i] & arr_q[i] & ~iss_q[i] & ~done_q[i] & prefix_ok;
      prefix_ok = prefix_ok & finished[i];
    end
  end

  always_comb begin
    for (int j = 0; j < NUM_ID; j++) begin
      conf[j] = new_st & mask_q[j] & arr_q[j] & ~st_q[j]
              & (iss_q[j] | hs_vec[j] | done_q[j])
              & (addr_q[j] == new_addr) & (ID_W'(j) > new_id);
    end
  end
endmodule

// File: rtl/lsq_order_top.sv
module lsq_order_top #(
  parameter int NUM_ID = 32,
  parameter int ADDR_W = 16,
  localparam int ID_W = $clog2(NUM_ID)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              spec_en,
  input  logic              mask_valid,
  input  logic [NUM_ID-1:0] mask_bits,
  output logic              mask_err,
  input  logic              op_valid,
  output logic              op_ready,
  input  logic [ID_W-1:0]   op_id,
  input  logic              op_store,
  input  logic [ADDR_W-1:0] op_addr,
  output logic              iss_valid,
  input  logic              iss_ready,
  output logic [ID_W-1:0]   iss_id,
  output logic              iss_store,
  output logic [ADDR_W-1:0] iss_addr,
  input  logic              cpl_valid,
  input  logic [ID_W-1:0]   cpl_id,
  output logic              commit,
  output logic              squash_valid,
  output logic [ID_W-1:0]   squash_id
);
  import lsq_pkg::*;

  blk_phase_e                    phase;
  logic [NUM_ID-1:0]             mask_q, arr_q, st_q, iss_q, done_q;
  logic [NUM_ID-1:0][ADDR_W-1:0] addr_q;

  logic [NUM_ID-1:0] elig, conf, gnt, sq_gnt, hs_vec, cpl_vec, conf_v;
  logic [ID_W-1:0]   pick_idx, sq_idx;
  logic              pick_any, sq_any, all_done, op_take;

  assign all_done = &(done_q | ~mask_q);
  assign op_ready = (phase == PH_RUN) && !all_done;
  assign op_take  = op_valid && op_ready && mask_q[op_id] && !arr_q[op_id];
  assign hs_vec   = iss_ready ? gnt : '0;
  assign cpl_vec  = cpl_valid ? (iss_q & (NUM_ID'(1) << cpl_id)) : '0;
  assign conf_v   = op_take ? conf : '0;

  lsq_hazard #(.NUM_ID(NUM_ID), .ADDR_W(ADDR_W)) u_hazard (
    .spec_en  (spec_en),
    .mask_q   (mask_q),
    .arr_q    (arr_q),
    .st_q     (st_q),
    .iss_q    (iss_q),
    .done_q   (done_q),
    .addr_q   (addr_q),
    .hs_vec   (hs_vec),
    .new_st   (op_store),
    .new_id   (op_id),
    .new_addr (op_addr),
    .elig     (elig),
    .conf     (conf)
  );

  lsq_pick #(.N(NUM_ID)) u_issue_pick (
    .req (elig),
    .gnt (gnt),
    .idx (pick_idx),
    .any (pick_any)
  );

  lsq_pick #(.N(NUM_ID)) u_squash_pick (
    .req (conf_v),
    .gnt (sq_gnt),
    .idx (sq_idx),
    .any (sq_any)
  );

  assign iss_valid = pick_any;
  assign iss_id    = pick_idx;
  assign iss_store = st_q[pick_idx];
  assign iss_addr  = addr_q[pick_idx];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase        <= PH_IDLE;
      mask_q       <= '0;
      arr_q        <= '0;
      st_q         <= '0;
      iss_q        <= '0;
      done_q       <= '0;
      addr_q       <= '0;
      mask_err     <= 1'b0;
      commit       <= 1'b0;
      squash_valid <= 1'b0;
      squash_id    <= '0;
    end else begin
      mask_err     <= mask_valid && (phase == PH_RUN);
      commit       <= 1'b0;
      squash_valid <= 1'b0;
      if (phase == PH_IDLE) begin
        if (mask_valid) begin
          mask_q <= mask_bits;
          arr_q  <= '0;
          iss_q  <= '0;
          done_q <= '0;
          phase  <= PH_RUN;
        end
      end else if (all_done) begin
        phase  <= PH_IDLE;
        commit <= 1'b1;
      end else begin
        if (op_take) begin
          arr_q[op_id]  <= 1'b1;
          st_q[op_id]   <= op_store;
          addr_q[op_id] <= op_addr;
        end
        iss_q        <= (iss_q | hs_vec) & ~conf_v;
        done_q       <= (done_q | cpl_vec) & ~conf_v;
        squash_valid <= sq_any;
        squash_id    <= sq_idx;
      end
    end
  end

  AST_ERR_ONLY_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
    mask_valid && (phase == PH_RUN) |=> mask_err); // R3
  AST_COMMIT_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> !commit); // R8
  AST_COMMIT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    commit |-> !iss_valid && !op_ready); // R8
  AST_IDLE_NO_ISSUE: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_IDLE) |-> !iss_valid); // R2
  AST_PICK_AGREE: assert property (@(posedge clk) disable iff (!rst_n)
    iss_valid |-> gnt[pick_idx] && $onehot0(gnt)); // R5
  AST_SQUASH_HAS_STORE: assert property (@(posedge clk) disable iff (!rst_n)
    squash_valid |-> $past(op_valid && op_store)); // R11
endmodule

// File: tb/sim_lsq_order_top.sv
module sim_lsq_order_top;
  localparam int NUM_ID = 32;
  localparam int ADDR_W = 16;
  localparam int ID_W   = 5;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              spec_en = 1'b0;
  logic              mask_valid = 1'b0;
  logic [NUM_ID-1:0] mask_bits = '0;
  logic              mask_err;
  logic              op_valid = 1'b0;
  logic              op_ready;
  logic [ID_W-1:0]   op_id = '0;
  logic              op_store = 1'b0;
  logic [ADDR_W-1:0] op_addr = '0;
  logic              iss_valid;
  logic              iss_ready = 1'b0;
  logic [ID_W-1:0]   iss_id;
  logic              iss_store;
  logic [ADDR_W-1:0] iss_addr;
  logic              cpl_valid = 1'b0;
  logic [ID_W-1:0]   cpl_id = '0;
  logic              commit;
  logic              squash_valid;
  logic [ID_W-1:0]   squash_id;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  lsq_order_top #(.NUM_ID(NUM_ID), .ADDR_W(ADDR_W)) u0 (.*);

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic load_mask(input logic [NUM_ID-1:0] m);
    mask_valid = 1'b1; mask_bits = m;
    tick();
    mask_valid = 1'b0;
  endtask

  task automatic send_op(input int id, input logic st, input logic [ADDR_W-1:0] a);
    op_valid = 1'b1; op_id = ID_W'(id); op_store = st; op_addr = a;
    tick();
    op_valid = 1'b0;
  endtask

  task automatic complete(input int id);
    cpl_valid = 1'b1; cpl_id = ID_W'(id);
    tick();
    cpl_valid = 1'b0;
  endtask

  task automatic take();
    iss_ready = 1'b1;
    tick();
    iss_ready = 1'b0;
  endtask

  task automatic expect_offer(input string tag, input int id);
    chk({tag, " valid"}, 32'(iss_valid), 32'd1);
    chk({tag, " id"}, 32'(iss_id), 32'(id));
  endtask

  task automatic t_reset();
    chk("R1 iss_valid", 32'(iss_valid), 0);
    chk("R1 commit", 32'(commit), 0);
    chk("R1 squash", 32'(squash_valid), 0);
    chk("R1 mask_err", 32'(mask_err), 0);
    chk("R1 op_ready", 32'(op_ready), 0);
  endtask

  task automatic t_strict();
    spec_en = 1'b0;
    load_mask(32'h0000_0224);              // ids 2,5,9
    chk("R2 op_ready", 32'(op_ready), 1);
    send_op(9, 1'b0, 16'h0040);
    send_op(5, 1'b1, 16'h0050);
    chk("R4 no early issue", 32'(iss_valid), 0);
    send_op(2, 1'b0, 16'h0060);
    expect_offer("R5 lowest", 2);
    tick();
    expect_offer("R5 held under backpressure", 2);
    load_mask(32'hFFFF_FFFF);
    chk("R3 mask_err", 32'(mask_err), 1);
    tick();
    chk("R3 mask_err drop", 32'(mask_err), 0);
    complete(9);                           // not issued: ignored
    take();
    chk("R4 store waits", 32'(iss_valid), 0);
    complete(2);
    expect_offer("R4 store released", 5);
    chk("R5 iss_store", 32'(iss_store), 1);
    chk("R5 iss_addr", 32'(iss_addr), 32'h50);
    send_op(20, 1'b0, 16'h0070);           // outside vector
    expect_offer("R6 unmasked ignored", 5);
    take();
    chk("R4 load waits", 32'(iss_valid), 0);
    complete(5);
    expect_offer("R7 early completion ignored", 9);
    take();
    complete(9);
    chk("R8 no commit yet", 32'(commit), 0);
    tick();
    chk("R8 commit", 32'(commit), 1);
    chk("R8 op_ready low", 32'(op_ready), 0);
    tick();
    chk("R8 commit single", 32'(commit), 0);
    chk("R6 never offered", 32'(iss_valid), 0);
  endtask

  task automatic t_empty();
    load_mask('0);
    chk("R8 empty no commit yet", 32'(commit), 0);
    tick();
    chk("R8 empty commit", 32'(commit), 1);
    tick();
  endtask

  task automatic t_spec();
    spec_en = 1'b1;
    load_mask(32'h0000_005A);              // ids 1,3,4,6
    send_op(4, 1'b0, 16'h0020);
    expect_offer("R9 load ahead", 4);
    chk("R9 addr", 32'(iss_addr), 32'h20);
    take();
    send_op(1, 1'b1, 16'h0010);
    chk("R9 diff addr no squash", 32'(squash_valid), 0);
    expect_offer("R9 store 1", 1);
    send_op(3, 1'b0, 16'h0010);
    take();
    chk("R10 same addr load held", 32'(iss_valid), 0);
    complete(1);
    expect_offer("R10 released", 3);
    take();
    send_op(6, 1'b1, 16'h0030);
    chk("R9 store waits", 32'(iss_valid), 0);
    complete(3);
    chk("R9 store still waits", 32'(iss_valid), 0);
    complete(4);
    expect_offer("R9 store released", 6);
    take();
    complete(6);
    tick();
    chk("R8 spec commit", 32'(commit), 1);
    tick();
  endtask

  task automatic t_squash();
    spec_en = 1'b1;
    load_mask(32'h0000_0184);              // ids 2,7,8
    send_op(7, 1'b0, 16'h0030);
    send_op(8, 1'b0, 16'h0030);
    expect_offer("R9 load 7", 7);
    take();
    expect_offer("R9 load 8", 8);
    take();
    complete(8);
    op_valid = 1'b1; op_id = 5'd2; op_store = 1'b1; op_addr = 16'h0030;
    cpl_valid = 1'b1; cpl_id = 5'd7;
    tick();
    op_valid = 1'b0; cpl_valid = 1'b0;
    chk("R11 squash", 32'(squash_valid), 1);
    chk("R11 squash id", 32'(squash_id), 7);
    chk("R12 no commit", 32'(commit), 0);
    expect_offer("R11 store first", 2);
    tick();
    chk("R11 squash single", 32'(squash_valid), 0);
    take();
    complete(2);
    expect_offer("R12 load 7 again", 7);
    take();
    complete(7);
    expect_offer("R11 load 8 again", 8);
    take();
    complete(8);
    tick();
    chk("R8 commit after replay", 32'(commit), 1);
    tick();
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    tick(); tick();
    t_reset();
    rst_n = 1'b1;
    tick();
    t_strict();
    t_empty();
    t_spec();
    t_squash();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule